// File: doc/BRIEF.md
# Serial Converter Acquisition Master

This block is the host side of a link to a 12-bit successive-approximation converter with a three-wire serial port. It makes the serial clock by dividing the system clock and drives chip select. It shifts in each read frame and passes on the converted code together with the input channel that produced it.

The converter returns, in every frame, the sample it took in the frame before. On the two-input variant it also changes input at the end of each full frame. The controller therefore keeps its own copy of the channel sequence and tags each result one frame late. It keeps chip select low through the conversion window after the read bits. It can run a deliberately short frame that puts the converter back on input 0, and it runs one such frame by itself after reset so that the channel sequence is known. Results leave as a one-cycle valid pulse with a 12-bit code and a 1-bit channel tag.

Top module: `adc_acq_ctrl`

## Requirements
- R1: After reset, `cs_n` is high, `sclk` is low and `res_valid` is low. `sclk` then runs continuously with a period of 2*HALF_DIV system clocks.
- R2: `cs_n` falls in the same system cycle in which `sclk` rises. The first falling edge of `sclk` in a frame samples the most significant bit on `sdo`, and every bit is sampled on a falling edge.
- R3: A full frame samples 16 bits. The first 12 bits form the code, most significant first, and the last 4 bits are dropped whatever their value.
- R4: A full frame keeps `cs_n` low for exactly 16 + 28 = 44 falling `sclk` edges. A short frame keeps it low for exactly 5.
- R5: `cs_n` stays high across at least one falling `sclk` edge between any two frames.
- R6: Each result is tagged with the channel that was sampled in the previous full frame.
- R7: With DUAL_INPUT=1, the tags of consecutive results alternate. With DUAL_INPUT=0, the tag is always 0.
- R8: A pulse on `chan_reset_req` makes the next frame a short frame. A short frame emits no result, and the channel tagged on the next sample is 0.
- R9: The first full frame after reset, and the first full frame after a short frame, emit no result.
- R10: `res_valid` is a single-cycle pulse. `res_code` passes the unipolar straight-binary code unchanged, including 000h and FFFh.
- R11: While `run` is low, no full frame starts. A frame already running finishes.
- R12: Reset sets a pending short frame, so the first frame after reset is a short frame, whatever the level of `run`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Allows full frames to start |
| chan_reset_req | input | 1 | Pulse that requests a short channel-reset frame |
| sdo | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock to the converter, idles low |
| cs_n | output | 1 | Chip select to the converter, active low |
| res_valid | output | 1 | One-cycle pulse when a result is ready |
| res_code | output | 12 | Converted code |
| res_chan | output | 1 | Input channel the code belongs to |

## Verification
The assertions assume that `rst` is held for at least one full half-period of the serial clock. They also assume that HALF_DIV is at least 2, so that a chip-select edge and the next serial-clock falling edge never land in the same system cycle. The stimulus holds reset for several cycles and uses the default divider. The bench converter model drives `sdo` only half a system cycle after a serial-clock falling edge, so every bit is stable when the controller samples it. It drives the four padding bits with a non-zero pattern, so that any leak of those bits into `res_code` shows up.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_READ,
    ST_CONV,
    ST_SHORT
  } seq_state_t;
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_DIV = 5
) (
  input  logic clk,
  input  logic rst,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] div_q;
  logic          tick;

  assign tick      = (div_q == CW'(HALF_DIV - 1));
  assign rise_tick = tick & ~sclk;
  assign fall_tick = tick & sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      sclk  <= 1'b0;
    end else if (tick) begin
      div_q <= '0;
      sclk  <= ~sclk;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
  import adc_acq_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int CONV_CLKS  = 28,
  parameter int SHORT_CLKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic chan_reset_req,
  input  logic rise_tick,
  input  logic fall_tick,
  output logic cs_n,
  output logic bit_strobe,
  output logic read_last,
  output logic short_done
);
  localparam int MAXC = (CONV_CLKS > FRAME_BITS) ? CONV_CLKS : FRAME_BITS;
  localparam int CNW  = $clog2(MAXC + 1);

  seq_state_t     st_q;
  logic [CNW-1:0] cnt_q;
  logic           short_pend_q;
  logic           start_short;
  logic           start_read;

  assign start_short = (st_q == ST_ARM) && rise_tick && short_pend_q;
  assign start_read  = (st_q == ST_ARM) && rise_tick && !short_pend_q && run;
  assign bit_strobe  = (st_q == ST_READ) && fall_tick;
  assign read_last   = bit_strobe && (cnt_q == CNW'(FRAME_BITS - 1));
  assign short_done  = (st_q == ST_SHORT) && fall_tick && (cnt_q == CNW'(SHORT_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      cs_n         <= 1'b1;
      short_pend_q <= 1'b1;
    end else begin
      if (chan_reset_req)
        short_pend_q <= 1'b1;
      else if (start_short)
        short_pend_q <= 1'b0;

      unique case (st_q)
        ST_IDLE: begin
          if (fall_tick) st_q <= ST_ARM;
        end
        ST_ARM: begin
          if (start_short) begin
            st_q  <= ST_SHORT;
            cs_n  <= 1'b0;
            cnt_q <= '0;
          end else if (start_read) begin
            st_q  <= ST_READ;
            cs_n  <= 1'b0;
            cnt_q <= '0;
          end
        end
        ST_READ: begin
          if (read_last) begin
            st_q  <= ST_CONV;
            cnt_q <= '0;
          end else if (fall_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_CONV: begin
          if (fall_tick) begin
            if (cnt_q == CNW'(CONV_CLKS - 1)) begin
              st_q <= ST_IDLE;
              cs_n <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_SHORT: begin
          if (short_done) begin
            st_q <= ST_IDLE;
            cs_n <= 1'b1;
          end else if (fall_tick) begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_shift_capture.sv
module adc_shift_capture #(
  parameter int FRAME_BITS = 16,
  parameter int RES_BITS   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sdo,
  input  logic                bit_strobe,
  output logic [RES_BITS-1:0] code
);
  logic [FRAME_BITS-1:0] shreg_q;
  logic [FRAME_BITS-1:0] shnext;

  assign shnext = {shreg_q[FRAME_BITS-2:0], sdo};
  assign code   = shnext[FRAME_BITS-1 -: RES_BITS];

  always_ff @(posedge clk) begin
    if (rst)
      shreg_q <= '0;
    else if (bit_strobe)
      shreg_q <= shnext;
  end
endmodule

// File: rtl/adc_chan_tracker.sv
module adc_chan_tracker #(
  parameter int RES_BITS   = 12,
  parameter bit DUAL_INPUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                read_last,
  input  logic                short_done,
  input  logic [RES_BITS-1:0] code,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_code,
  output logic                res_chan
);
  logic cur_ch_q;
  logic prev_ch_q;
  logic prev_ok_q;
  logic next_ch;

  generate
    if (DUAL_INPUT) begin : g_dual
      assign next_ch = ~cur_ch_q;
    end else begin : g_single
      assign next_ch = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_ch_q  <= 1'b0;
      prev_ch_q <= 1'b0;
      prev_ok_q <= 1'b0;
      res_valid <= 1'b0;
      res_code  <= '0;
      res_chan  <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (read_last) begin
        res_valid <= prev_ok_q;
        res_code  <= code;
        res_chan  <= prev_ch_q;
        prev_ch_q <= cur_ch_q;
        prev_ok_q <= 1'b1;
        cur_ch_q  <= next_ch;
      end else if (short_done) begin
        cur_ch_q  <= 1'b0;
        prev_ok_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl #(
  parameter int HALF_DIV   = 5,
  parameter int RES_BITS   = 12,
  parameter int FRAME_BITS = 16,
  parameter int CONV_CLKS  = 28,
  parameter int SHORT_CLKS = 5,
  parameter bit DUAL_INPUT = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                chan_reset_req,
  input  logic                sdo,
  output logic                sclk,
  output logic                cs_n,
  output logic                res_valid,
  output logic [RES_BITS-1:0] res_code,
  output logic                res_chan
);
  logic rise_tick;
  logic fall_tick;
  logic bit_strobe;
  logic read_last;
  logic short_done;
  logic [RES_BITS-1:0] code;

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  adc_frame_seq #(
    .FRAME_BITS (FRAME_BITS),
    .CONV_CLKS  (CONV_CLKS),
    .SHORT_CLKS (SHORT_CLKS)
  ) u_seq (
    .clk            (clk),
    .rst            (rst),
    .run            (run),
    .chan_reset_req (chan_reset_req),
    .rise_tick      (rise_tick),
    .fall_tick      (fall_tick),
    .cs_n           (cs_n),
    .bit_strobe     (bit_strobe),
    .read_last      (read_last),
    .short_done     (short_done)
  );

  adc_shift_capture #(
    .FRAME_BITS (FRAME_BITS),
    .RES_BITS   (RES_BITS)
  ) u_cap (
    .clk        (clk),
    .rst        (rst),
    .sdo        (sdo),
    .bit_strobe (bit_strobe),
    .code       (code)
  );

  adc_chan_tracker #(
    .RES_BITS   (RES_BITS),
    .DUAL_INPUT (DUAL_INPUT)
  ) u_trk (
    .clk        (clk),
    .rst        (rst),
    .read_last  (read_last),
    .short_done (short_done),
    .code       (code),
    .res_valid  (res_valid),
    .res_code   (res_code),
    .res_chan   (res_chan)
  );
endmodule

// File: rtl/adc_acq_ctrl_chk.sv
module adc_acq_ctrl_chk #(
  parameter int FULL_FALLS  = 44,
  parameter int SHORT_FALLS = 5
) (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sclk,
  input logic res_valid
);
  logic sclk_q;
  logic csn_q;
  int   lo_cnt;
  int   hi_cnt;
  logic sfall;

  assign sfall = sclk_q & ~sclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
      lo_cnt <= 0;
      hi_cnt <= 0;
    end else begin
      sclk_q <= sclk;
      csn_q  <= cs_n;
      if (csn_q && !cs_n)
        lo_cnt <= 0;
      else if (sfall && !csn_q)
        lo_cnt <= lo_cnt + 1;
      if (!csn_q && cs_n)
        hi_cnt <= 0;
      else if (sfall && csn_q && cs_n)
        hi_cnt <= hi_cnt + 1;
    end
  end

  // R2: chip select drops together with a rising serial clock
  a_r2_cs_on_rise: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> sclk);

  // R4: low window length is either the full or the short frame
  a_r4_frame_len: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |=> (lo_cnt == FULL_FALLS || lo_cnt == SHORT_FALLS));

  // R5: a falling serial clock edge occurs while chip select is high
  a_r5_gap_edge: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= 1));

  // R10: result strobe lasts one cycle
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9: results only come out inside a full frame
  a_r9_valid_in_frame: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !cs_n);
endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk #(
  .FULL_FALLS  (FRAME_BITS + CONV_CLKS),
  .SHORT_FALLS (SHORT_CLKS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .res_valid (res_valid)
);

// File: tb/adc_acq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_acq_ctrl_tb;
  localparam int HALF_DIV = 5;
  localparam int NV = 8;
  localparam logic [11:0] SAMPLE_TBL [NV] = '{12'h000, 12'hFFF, 12'h800, 12'h7FF,
                                              12'h001, 12'hFFE, 12'hA5A, 12'h5A5};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic chan_reset_req = 1'b0;
  logic sdo = 1'b0;
  logic sclk, cs_n, res_valid, res_chan;
  logic [11:0] res_code;

  adc_acq_ctrl #(.HALF_DIV(HALF_DIV)) u_dut (
    .clk(clk), .rst(rst), .run(run), .chan_reset_req(chan_reset_req), .sdo(sdo),
    .sclk(sclk), .cs_n(cs_n), .res_valid(res_valid), .res_code(res_code), .res_chan(res_chan)
  );

  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model state
  logic        sclk_p = 1'b0, csn_p = 1'b1, valid_p = 1'b0;
  logic        dev_ch = 1'b0, held_ch = 1'b0, have_prev = 1'b0;
  logic [11:0] held_val = 12'h3C3;
  logic [15:0] tx = '0;
  int lo = 0, hi = 0, sidx = 0;
  int full_frames = 0, short_frames = 0, cs_falls = 0;
  logic [11:0] exp_val [128];
  logic        exp_ch  [128];
  logic [11:0] got_val [128];
  logic        got_ch  [128];
  int exp_n = 0, got = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (csn_p && !cs_n) begin
        chk(hi >= 1, "R5", "falls while cs high", hi, 1);
        chk(sclk == 1'b1, "R2", "sclk at cs fall", sclk, 1);
        tx = {held_val, 4'b1010};
        sdo = tx[15];
        lo = 0;
        hi = 0;
        cs_falls++;
      end
      if (sclk_p && !sclk) begin
        if (!csn_p) begin
          lo++;
          if (lo == 16) begin
            if (have_prev) begin
              exp_val[exp_n] = held_val;
              exp_ch[exp_n]  = held_ch;
              exp_n++;
            end
            held_val  = SAMPLE_TBL[sidx % NV];
            held_ch   = dev_ch;
            have_prev = 1'b1;
            sidx++;
          end else begin
            tx  = {tx[14:0], 1'b0};
            sdo = tx[15];
          end
        end else begin
          hi++;
        end
      end
      if (!csn_p && cs_n) begin
        chk(lo == 44 || lo == 5, "R4", "falls while cs low", lo, 44);
        if (lo >= 4 && lo <= 7) begin
          dev_ch = 1'b0;
          have_prev = 1'b0;
          short_frames++;
        end else if (lo >= 44) begin
          dev_ch = ~dev_ch;
          full_frames++;
        end
      end
      if (res_valid) begin
        chk(got < exp_n, "R9", "unexpected result", got, exp_n);
        if (got < exp_n) begin
          chk(res_code == exp_val[got], "R3", "result code", res_code, exp_val[got]);
          chk(res_chan == exp_ch[got], "R6", "result channel", res_chan, exp_ch[got]);
        end
        got_val[got] = res_code;
        got_ch[got]  = res_chan;
        got++;
      end
      if (res_valid && valid_p)
        chk(1'b0, "R10", "valid longer than one cycle", 2, 1);
    end
    sclk_p  = sclk;
    csn_p   = cs_n;
    valid_p = res_valid;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    realtime t0, t1;
    int g, f, s0, c0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "cs_n in reset", cs_n, 1);
    chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
    rst = 1'b0;

    @(posedge sclk); t0 = $realtime;
    @(posedge sclk); t1 = $realtime;
    chk(int'((t1 - t0) / 5.0) == 2 * HALF_DIV, "R1", "sclk period", int'((t1 - t0) / 5.0), 2 * HALF_DIV);

    // R12: automatic short frame with run still low
    wait (short_frames >= 1);
    chk(full_frames == 0, "R12", "full frames before short", full_frames, 0);
    chk(got == 0, "R8", "results after short frame", got, 0);
    @(negedge clk); run = 1'b1;

    wait (full_frames >= 1);
    @(negedge clk);
    chk(got == 0, "R9", "results after first full frame", got, 0);

    for (int i = 0; i < NV; i++) begin
      wait (full_frames >= i + 2);
      @(negedge clk);
      chk(got == i + 1, "R3", "result count", got, i + 1);
      chk(got_val[i] == SAMPLE_TBL[i], "R10", "code passthrough", got_val[i], SAMPLE_TBL[i]);
      if (i > 0)
        chk(got_ch[i] != got_ch[i-1], "R7", "channel alternation", got_ch[i], ~got_ch[i-1]);
    end

    // R8: requested short frame
    s0 = short_frames;
    @(negedge clk); chan_reset_req = 1'b1;
    @(negedge clk); chan_reset_req = 1'b0;
    wait (short_frames >= s0 + 1);
    @(negedge clk);
    g = got; f = full_frames;
    wait (full_frames >= f + 1);
    @(negedge clk);
    chk(got == g, "R9", "results after short then full", got, g);
    wait (full_frames >= f + 2);
    @(negedge clk);
    chk(got == g + 1, "R8", "result count after short", got, g + 1);
    chk(got_ch[g] == 1'b0, "R8", "channel after short", got_ch[g], 0);

    // R11: run low stops new frames
    wait (full_frames >= f + 3);
    run = 1'b0;
    c0 = cs_falls; g = got;
    repeat (1000) @(posedge clk);
    @(negedge clk);
    chk(cs_falls == c0, "R11", "frames started with run low", cs_falls - c0, 0);
    chk(got == g, "R11", "results with run low", got, g);

    // reset while idle
    rst = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(cs_n == 1'b1 && res_valid == 1'b0, "R1", "outputs in second reset", cs_n, 1);
    rst = 1'b0;
    s0 = short_frames;
    wait (short_frames >= s0 + 1);
    chk(1'b1, "R12", "short frame after second reset", 1, 1);
    @(negedge clk); run = 1'b1;
    g = got; f = full_frames;
    wait (full_frames >= f + 1);
    @(negedge clk);
    chk(got == g, "R9", "results after reset first frame", got, g);
    wait (full_frames >= f + 2);
    @(negedge clk);
    chk(got == g + 1, "R9", "results after reset second frame", got, g + 1);
    chk(got_ch[g] == 1'b0, "R6", "channel after reset", got_ch[g], 0);
    chk(got == exp_n, "R9", "total results", got, exp_n);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule